// File: doc/BRIEF.md
# Auto-Detecting Dual-Mode Host Register Port

This block is the host-facing register access port of an 8-bit peripheral with sixteen register addresses. A host processor reaches the registers in one of two bus styles. In the shared-pin style, the address travels on the data pins and is held by an address-latch strobe. Separate active-low read and write strobes then move the data. In the separate-pin style, four dedicated pins carry the address. One strobe pin gives the transfer direction and the other is an active-low enable.

The port starts in the separate-pin style. It moves to the shared-pin style for good on the first rising edge of the address-latch strobe. All bus pins are brought into the core clock through synchronizer flops. For each access the block issues exactly one single-cycle read or write request to the register file, and it drives the data pins only during a valid read. The register file answers a read request combinationally in the cycle the request is high.

Top module: `hbus_port`

## Requirements
- R1: After reset, `mux_mode` is 0 and `bus_d_oe`, `reg_we` and `reg_re` are 0.
- R2: `mux_mode` goes to 1 after a low-to-high transition on `bus_ale` and then stays 1 until reset. With `bus_ale` held low it stays 0.
- R3: With `mux_mode` = 1, the register address is bits [3:0] of `bus_d_in` as last seen while `bus_ale` was high, and the values on `bus_addr` have no effect.
- R4: With `mux_mode` = 1, each low pulse of `bus_rd_n` while `bus_cs_n` is low gives exactly one `reg_re` pulse. `bus_d_out` then shows the returned register value while `bus_d_oe` is 1.
- R5: With `mux_mode` = 1, each low pulse of `bus_wr_n` while `bus_cs_n` is low gives exactly one `reg_we` pulse at the end of the pulse. The pulse carries the `bus_d_in` value present just before the strobe rose.
- R6: With `mux_mode` = 0, a read takes place while `bus_cs_n` = 0, `bus_wr_n` (enable) = 0 and `bus_rd_n` (direction) = 1. The address is taken from `bus_addr`, and the data is driven with `bus_d_oe` = 1 during that access.
- R7: With `mux_mode` = 0, a write takes place when `bus_cs_n`, `bus_wr_n` and `bus_rd_n` are all 0. Exactly one `reg_we` pulse, with address `bus_addr` and data `bus_d_in`, follows when the access ends.
- R8: While `bus_cs_n` = 1, no strobe activity produces `reg_we`, `reg_re` or `bus_d_oe`.
- R9: `bus_d_oe` is 0 outside a read access. It rises only in the cycle after a `reg_re` pulse, and it falls once the read condition ends.
- R10: `reg_we` and `reg_re` are never high together. When a write finishes in the same cycle a read begins, `reg_we` comes first and `reg_re` follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst | input | 1 | synchronous active-high reset |
| bus_cs_n | input | 1 | chip select, active low |
| bus_ale | input | 1 | address-latch strobe (shared-pin style) |
| bus_rd_n | input | 1 | read strobe (shared) / direction, 1 = read (separate) |
| bus_wr_n | input | 1 | write strobe (shared) / enable, active low (separate) |
| bus_addr | input | 4 | dedicated address pins (separate-pin style) |
| bus_d_in | input | 8 | data pins, input side |
| bus_d_out | output | 8 | data pins, output side |
| bus_d_oe | output | 1 | data pin output enable |
| mux_mode | output | 1 | 1 once the shared-pin style is detected |
| reg_addr | output | 4 | register address for the request |
| reg_wdata | output | 8 | register write data |
| reg_we | output | 1 | single-cycle register write request |
| reg_re | output | 1 | single-cycle register read request |
| reg_rdata | input | 8 | register read data, valid in the `reg_re` cycle |

## Verification
The end of a write and the start of a read can land in the same core cycle. In the separate-pin style, this happens when the direction pin flips from write to read while enable and chip select stay low. The bench provokes it by toggling only the direction line. It records the cycle of each request pulse and expects the write request first, the read request exactly one cycle later, both at the same address, and read data on the bus afterwards.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

  typedef enum logic {
    MODE_SEPARATE = 1'b0,
    MODE_SHARED   = 1'b1
  } bus_mode_e;

  // read condition for the present bus style
  function automatic logic rd_cond(bus_mode_e m, logic cs_n, logic rd_n, logic wr_n);
    if (m == MODE_SHARED) return !cs_n && !rd_n;
    else                  return !cs_n && !wr_n && rd_n;
  endfunction

  // write condition for the present bus style
  function automatic logic wr_cond(bus_mode_e m, logic cs_n, logic rd_n, logic wr_n);
    if (m == MODE_SHARED) return !cs_n && !wr_n;
    else                  return !cs_n && !wr_n && !rd_n;
  endfunction

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int W       = 1,
  parameter int STAGES  = 2,
  parameter logic RST_V = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= {W{RST_V}};
        else if (g == 0) chain[g] <= d;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hbus_mode_det.sv
module hbus_mode_det
  import hbus_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ale_s,
  output bus_mode_e mode
);
  logic ale_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_prev <= 1'b1;
      mode     <= MODE_SEPARATE;
    end else begin
      ale_prev <= ale_s;
      if (ale_s && !ale_prev) mode <= MODE_SHARED;
    end
  end
endmodule

// File: rtl/hbus_addr_sel.sv
module hbus_addr_sel
  import hbus_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  bus_mode_e     mode,
  input  logic          ale_s,
  input  logic [AW-1:0] data_lo_s,
  input  logic [AW-1:0] pin_addr_s,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] latched;

  always_ff @(posedge clk) begin
    if (rst)        latched <= '0;
    else if (ale_s) latched <= data_lo_s;
  end

  assign addr = (mode == MODE_SHARED) ? latched : pin_addr_s;
endmodule

// File: rtl/hbus_access.sv
module hbus_access
  import hbus_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  bus_mode_e     mode,
  input  logic          cs_n_s,
  input  logic          rd_n_s,
  input  logic          wr_n_s,
  input  logic [AW-1:0] addr_s,
  input  logic [DW-1:0] din_s,
  input  logic [DW-1:0] reg_rdata,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  output logic          reg_re,
  output logic [DW-1:0] d_out,
  output logic          d_oe
);
  logic          rd_now, wr_now;
  logic          rd_q, wr_q, rd_pend, dvalid;
  logic [AW-1:0] addr_p;
  logic [DW-1:0] din_p;
  logic          wr_end, rd_start, want_rd;

  assign rd_now   = rd_cond(mode, cs_n_s, rd_n_s, wr_n_s);
  assign wr_now   = wr_cond(mode, cs_n_s, rd_n_s, wr_n_s);
  assign wr_end   = wr_q && !wr_now;
  assign rd_start = rd_now && !rd_q;
  assign want_rd  = (rd_start || rd_pend) && rd_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q      <= 1'b0;
      wr_q      <= 1'b0;
      rd_pend   <= 1'b0;
      dvalid    <= 1'b0;
      addr_p    <= '0;
      din_p     <= '0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
      reg_re    <= 1'b0;
      d_out     <= '0;
      d_oe      <= 1'b0;
    end else begin
      rd_q    <= rd_now;
      wr_q    <= wr_now;
      addr_p  <= addr_s;
      din_p   <= din_s;
      reg_we  <= wr_end;
      reg_re  <= want_rd && !wr_end;
      rd_pend <= want_rd && wr_end;
      if (wr_end) begin
        reg_addr  <= addr_p;
        reg_wdata <= din_p;
      end else if (want_rd) begin
        reg_addr  <= addr_s;
      end
      if (reg_re) d_out <= reg_rdata;
      dvalid <= rd_now && (dvalid || reg_re);
      d_oe   <= rd_now && (dvalid || reg_re);
    end
  end
endmodule

// File: rtl/hbus_port.sv
module hbus_port
  import hbus_pkg::*;
#(
  parameter int AW      = 4,
  parameter int DW      = 8,
  parameter int SYNC_ST = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_cs_n,
  input  logic          bus_ale,
  input  logic          bus_rd_n,
  input  logic          bus_wr_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_d_in,
  output logic [DW-1:0] bus_d_out,
  output logic          bus_d_oe,
  output logic          mux_mode,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  output logic          reg_re,
  input  logic [DW-1:0] reg_rdata
);
  localparam int CW = 4;
  localparam int PW = AW + DW;

  logic [CW-1:0] ctl_s;
  logic [PW-1:0] pay_s;
  logic          cs_n_s, ale_s, rd_n_s, wr_n_s;
  logic [AW-1:0] pin_addr_s, sel_addr;
  logic [DW-1:0] din_s;
  bus_mode_e     mode;

  hbus_sync #(.W(CW), .STAGES(SYNC_ST), .RST_V(1'b1)) i_sync_ctl (
    .clk(clk), .rst(rst),
    .d({bus_cs_n, bus_ale, bus_rd_n, bus_wr_n}),
    .q(ctl_s)
  );

  hbus_sync #(.W(PW), .STAGES(SYNC_ST), .RST_V(1'b0)) i_sync_pay (
    .clk(clk), .rst(rst),
    .d({bus_addr, bus_d_in}),
    .q(pay_s)
  );

  assign {cs_n_s, ale_s, rd_n_s, wr_n_s} = ctl_s;
  assign pin_addr_s = pay_s[PW-1:DW];
  assign din_s      = pay_s[DW-1:0];

  hbus_mode_det i_mode (
    .clk(clk), .rst(rst), .ale_s(ale_s), .mode(mode)
  );

  hbus_addr_sel #(.AW(AW)) i_addr (
    .clk(clk), .rst(rst), .mode(mode), .ale_s(ale_s),
    .data_lo_s(din_s[AW-1:0]), .pin_addr_s(pin_addr_s), .addr(sel_addr)
  );

  hbus_access #(.AW(AW), .DW(DW)) i_acc (
    .clk(clk), .rst(rst), .mode(mode),
    .cs_n_s(cs_n_s), .rd_n_s(rd_n_s), .wr_n_s(wr_n_s),
    .addr_s(sel_addr), .din_s(din_s), .reg_rdata(reg_rdata),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re),
    .d_out(bus_d_out), .d_oe(bus_d_oe)
  );

  assign mux_mode = (mode == MODE_SHARED);
endmodule

// File: rtl/hbus_port_chk.sv
module hbus_port_chk (
  input logic clk,
  input logic rst,
  input logic mux_mode,
  input logic reg_we,
  input logic reg_re,
  input logic bus_d_oe
);
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && reg_re));

  a_r5_we_single: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  a_r4_re_single: assert property (@(posedge clk) disable iff (rst)
    reg_re |=> !reg_re);

  a_r2_mode_sticky: assert property (@(posedge clk) disable iff (rst)
    mux_mode |=> mux_mode);

  a_r9_oe_after_re: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_d_oe) |-> $past(reg_re));
endmodule

bind hbus_port hbus_port_chk i_hbus_port_chk (
  .clk(clk), .rst(rst), .mux_mode(mux_mode),
  .reg_we(reg_we), .reg_re(reg_re), .bus_d_oe(bus_d_oe)
);

// File: tb/test_hbus_port.sv
module test_hbus_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_cs_n = 1'b1, bus_ale = 1'b0, bus_rd_n = 1'b1, bus_wr_n = 1'b1;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_d_in = '0;
  logic [7:0] bus_d_out, reg_wdata, reg_rdata;
  logic       bus_d_oe, mux_mode, reg_we, reg_re;
  logic [3:0] reg_addr;

  int checks = 0, errors = 0, cyc = 0;
  int we_cnt = 0, re_cnt = 0, we_cyc = 0, re_cyc = 0;
  logic [3:0] we_addr, re_addr;
  logic [7:0] we_data;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] rval(input logic [3:0] a);
    return {a, ~a} ^ 8'h3C;
  endfunction
  assign reg_rdata = rval(reg_addr);

  hbus_port i_hbus_port (
    .clk(clk), .rst(rst), .bus_cs_n(bus_cs_n), .bus_ale(bus_ale),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_addr(bus_addr),
    .bus_d_in(bus_d_in), .bus_d_out(bus_d_out), .bus_d_oe(bus_d_oe),
    .mux_mode(mux_mode), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && reg_we) begin
      we_cnt++; we_cyc = cyc; we_addr = reg_addr; we_data = reg_wdata;
    end
    if (!rst && reg_re) begin
      re_cnt++; re_cyc = cyc; re_addr = reg_addr;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    wait_n(1);
    chk(mux_mode == 1'b0, "R1 mode", mux_mode, 0);
    chk(bus_d_oe == 1'b0, "R1 oe", bus_d_oe, 0);
    chk(reg_we == 1'b0 && reg_re == 1'b0, "R1 req", {reg_we, reg_re}, 0);
  endtask

  task automatic t_sep_write(input logic [3:0] a, input logic [7:0] d);
    int w0 = we_cnt;
    bus_addr = a; bus_d_in = d; bus_rd_n = 1'b0; bus_cs_n = 1'b0;
    wait_n(1); bus_wr_n = 1'b0;
    wait_n(4);
    chk(bus_d_oe == 1'b0, "R9 oe during write", bus_d_oe, 0);
    bus_wr_n = 1'b1; wait_n(2);
    bus_cs_n = 1'b1; bus_rd_n = 1'b1; wait_n(6);
    chk(we_cnt == w0 + 1, "R7 one write", we_cnt - w0, 1);
    chk(we_addr == a, "R7 addr", we_addr, a);
    chk(we_data == d, "R7 data", we_data, d);
  endtask

  task automatic t_sep_read(input logic [3:0] a);
    int r0 = re_cnt;
    bus_addr = a; bus_rd_n = 1'b1; bus_cs_n = 1'b0; bus_wr_n = 1'b0;
    wait_n(7);
    chk(bus_d_oe == 1'b1, "R6 oe", bus_d_oe, 1);
    chk(bus_d_out == rval(a), "R6 data", bus_d_out, rval(a));
    bus_wr_n = 1'b1; bus_cs_n = 1'b1; wait_n(6);
    chk(bus_d_oe == 1'b0, "R9 oe released", bus_d_oe, 0);
    chk(re_cnt == r0 + 1, "R6 one read", re_cnt - r0, 1);
    chk(re_addr == a, "R6 addr", re_addr, a);
  endtask

  task automatic t_cs_ignored;
    int w0 = we_cnt, r0 = re_cnt;
    bus_cs_n = 1'b1; bus_rd_n = 1'b0; bus_wr_n = 1'b0; bus_addr = 4'h7;
    wait_n(6);
    bus_rd_n = 1'b1; wait_n(6);
    chk(bus_d_oe == 1'b0, "R8 no oe", bus_d_oe, 0);
    bus_wr_n = 1'b1; wait_n(6);
    chk(we_cnt == w0 && re_cnt == r0, "R8 no requests",
        (we_cnt - w0) + (re_cnt - r0), 0);
  endtask

  task automatic t_collision(input logic [3:0] a, input logic [7:0] d);
    int w0 = we_cnt, r0 = re_cnt;
    bus_addr = a; bus_d_in = d; bus_rd_n = 1'b0; bus_cs_n = 1'b0;
    wait_n(1); bus_wr_n = 1'b0; wait_n(4);
    bus_rd_n = 1'b1; wait_n(7);
    chk(we_cnt == w0 + 1 && re_cnt == r0 + 1, "R10 both issued",
        (we_cnt - w0) * 16 + (re_cnt - r0), 17);
    chk(re_cyc == we_cyc + 1, "R10 read one cycle after write", re_cyc - we_cyc, 1);
    chk(we_addr == a && re_addr == a, "R10 addr", {we_addr, re_addr}, {a, a});
    chk(we_data == d, "R10 data", we_data, d);
    chk(bus_d_oe == 1'b1 && bus_d_out == rval(a), "R10 read data", bus_d_out, rval(a));
    bus_wr_n = 1'b1; bus_cs_n = 1'b1; wait_n(6);
  endtask

  task automatic latch_addr(input logic [3:0] a);
    bus_d_in = {4'h0, a}; bus_ale = 1'b1; wait_n(2);
    bus_ale = 1'b0; wait_n(1);
  endtask

  task automatic t_mode_switch;
    chk(mux_mode == 1'b0, "R2 stays separate with ale low", mux_mode, 0);
    latch_addr(4'h2); wait_n(3);
    chk(mux_mode == 1'b1, "R2 switched", mux_mode, 1);
  endtask

  task automatic t_mux_write(input logic [3:0] a, input logic [7:0] d, input logic [3:0] pin);
    int w0 = we_cnt;
    latch_addr(a);
    bus_addr = pin; bus_d_in = d; bus_cs_n = 1'b0; bus_rd_n = 1'b1;
    wait_n(1); bus_wr_n = 1'b0; wait_n(4);
    bus_wr_n = 1'b1; wait_n(2); bus_cs_n = 1'b1; wait_n(6);
    chk(we_cnt == w0 + 1, "R5 one write", we_cnt - w0, 1);
    chk(we_addr == a, "R3 latched addr, pins ignored", we_addr, a);
    chk(we_data == d, "R5 data", we_data, d);
  endtask

  task automatic t_mux_read(input logic [3:0] a, input logic [3:0] pin);
    int r0 = re_cnt;
    latch_addr(a);
    bus_addr = pin; bus_d_in = 8'hFF; bus_cs_n = 1'b0; bus_wr_n = 1'b1;
    wait_n(1); bus_rd_n = 1'b0; wait_n(7);
    chk(bus_d_oe == 1'b1, "R4 oe", bus_d_oe, 1);
    chk(bus_d_out == rval(a), "R4 data", bus_d_out, rval(a));
    bus_rd_n = 1'b1; bus_cs_n = 1'b1; wait_n(6);
    chk(bus_d_oe == 1'b0, "R9 oe released", bus_d_oe, 0);
    chk(re_cnt == r0 + 1, "R4 one read", re_cnt - r0, 1);
    chk(re_addr == a, "R3 read addr", re_addr, a);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    wait_n(4); rst = 1'b0;
    t_reset();
    t_sep_write(4'h3, 8'hA5);
    t_sep_write(4'hC, 8'h0F);
    t_sep_read(4'h6);
    t_cs_ignored();
    t_collision(4'h9, 8'h33);
    t_mode_switch();
    t_mux_write(4'h5, 8'hC3, 4'hA);
    t_mux_read(4'hE, 4'h1);
    wait_n(20);
    chk(mux_mode == 1'b1, "R2 sticky", mux_mode, 1);
    finish_run();
  end

  initial begin
    #(5.0 * 20000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule